// File: doc/BRIEF.md
# UART Transmit Status Flags

This block produces the two transmit-side status flags of a buffered UART. The first is a watermark flag that says the transmit queue has room. The second is a completion flag that says the line has gone quiet.

The surrounding UART supplies several inputs:
- the number of words waiting in the transmit queue (the word now in the shifter is not counted);
- a programmable watermark;
- activity indications from the shifter, the preamble generator and the break generator;
- one-cycle strobes for the register accesses that matter here.

Both flags are sticky. Each one clears only through a two-step handshake. First, software reads status while the flag is 1, which arms that flag. Later, a qualifying action removes it.

The completion flag also forces the serial output to its idle level. Both flags feed one transmit interrupt request through per-flag enables.

Top module: `uart_tx_status`

## Requirements
- R1: Out of reset both flags are 0. From the first cycle after reset, `tx_empty` is 1 in every cycle after one in which `fifo_level <= tx_watermark`.
- R2: `shifter_busy` plays no part in the empty flag. A word being shifted out is excluded because the count already excludes it.
- R3: An armed empty flag clears on a `data_wr` strobe when `fifo_level > tx_watermark` in that cycle. Arming means a `stat_rd` strobe in an earlier cycle, while the flag was 1.
- R4: If a set condition holds in the same cycle as a clearing action, the flag stays 1. The empty flag therefore keeps coming back until the queue exceeds the watermark. The clearing action consumes the arm.
- R5: `tx_done` becomes 1 after a cycle in which `fifo_level` is 0 and none of `shifter_busy`, `preamble_busy` and `break_busy` is 1.
- R6: `txd_idle_force` is 1 exactly when `tx_done` is 1.
- R7: An armed done flag clears on a `data_wr` strobe when its set condition is false. This includes a strobe in the same cycle as a further `stat_rd`.
- R8: An armed done flag clears when the transmitter enable is written 1 while its last written value was 0. The last written value is 0 out of reset. Writing 0 alone, or writing 1 while already enabled, does not clear it.
- R9: An armed done flag clears on `sbk_wr` with `sbk_wdata` = 1. `sbk_wr` with `sbk_wdata` = 0 has no effect on either flag.
- R10: A write that does not qualify for a flag leaves that flag's arm in place. Examples are a break or enable write for the empty flag, or a non-toggling enable write for the done flag. A later qualifying action still clears the flag.
- R11: Without a status read after the flag last became armed, no action clears it. A flag that sets again after a clear does not become armed by itself.
- R12: `tx_irq` = (`tx_empty` & `empty_ie`) | (`tx_done` & `done_ie`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_level | input | LVL_W | Queued words, not counting the one in the shifter |
| tx_watermark | input | LVL_W | Programmed transmit watermark |
| shifter_busy | input | 1 | A data character is being shifted out |
| preamble_busy | input | 1 | A preamble is being sent |
| break_busy | input | 1 | A break character is being sent |
| stat_rd | input | 1 | Status register read strobe |
| data_wr | input | 1 | Data register write strobe |
| txen_wr | input | 1 | Transmitter enable write strobe |
| txen_wdata | input | 1 | Value written to the transmitter enable |
| sbk_wr | input | 1 | Send-break control write strobe |
| sbk_wdata | input | 1 | Value written to the send-break control |
| empty_ie | input | 1 | Interrupt enable for the empty flag |
| done_ie | input | 1 | Interrupt enable for the done flag |
| tx_empty | output | 1 | Sticky watermark flag |
| tx_done | output | 1 | Sticky transmit-complete flag |
| tx_irq | output | 1 | Transmit interrupt request |
| txd_idle_force | output | 1 | Holds the serial output at logic 1 |

## Verification
The hardest situations to reach are the ones where a flag's arm has to survive, or has to be used up, across several register accesses.

One case is a non-qualifying enable or break write that sits between the read and the data write. Another is a clearing write that lands while the set condition still holds, which consumes the arm without dropping the flag. A third is a second write that then must not clear.

The stimulus reaches these by holding the queue level on one side of the watermark, and the activity inputs at chosen values, across scripted access sequences. The transmitter enable is first written 1 with nothing armed, so that a later re-write of 1 is a true non-toggle.

// File: rtl/uart_tx_status_pkg.sv
package uart_tx_status_pkg;

    localparam int FLAG_EMPTY = 0;
    localparam int FLAG_DONE  = 1;
    localparam int NUM_FLAGS  = 2;

    // State of one sticky status flag
    typedef struct packed {
        logic flag;
        logic armed;   // a status read has seen the flag set
    } flag_state_t;

    // Control state kept by the action decoder
    typedef struct packed {
        logic te_last; // last value written to the transmitter enable
    } ctl_state_t;

endpackage

// File: rtl/tx_set_eval.sv
module tx_set_eval
    import uart_tx_status_pkg::*;
#(
    parameter int LVL_W = 4
) (
    input  logic [LVL_W-1:0]     level_i,
    input  logic [LVL_W-1:0]     water_i,
    input  logic                 shift_busy_i,
    input  logic                 pre_busy_i,
    input  logic                 brk_busy_i,
    output logic [NUM_FLAGS-1:0] set_o
);

    logic line_active;

    always_comb begin
        line_active          = shift_busy_i | pre_busy_i | brk_busy_i;
        set_o                = '0;
        // Room in the queue: the shifter word is already excluded from level_i
        set_o[FLAG_EMPTY]    = (level_i <= water_i);
        // Nothing queued and nothing on the wire
        set_o[FLAG_DONE]     = (level_i == '0) && !line_active;
    end

endmodule

// File: rtl/tx_action_decode.sv
module tx_action_decode
    import uart_tx_status_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 data_wr_i,
    input  logic                 txen_wr_i,
    input  logic                 txen_wdata_i,
    input  logic                 sbk_wr_i,
    input  logic                 sbk_wdata_i,
    output logic [NUM_FLAGS-1:0] act_o
);

    ctl_state_t ctl_d, ctl_q;
    logic       te_toggle;
    logic       brk_queue;

    always_comb begin
        ctl_d     = ctl_q;
        te_toggle = txen_wr_i & txen_wdata_i & ~ctl_q.te_last;
        brk_queue = sbk_wr_i & sbk_wdata_i;
        if (txen_wr_i) begin
            ctl_d.te_last = txen_wdata_i;
        end
        act_o             = '0;
        act_o[FLAG_EMPTY] = data_wr_i;
        act_o[FLAG_DONE]  = data_wr_i | te_toggle | brk_queue;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

endmodule

// File: rtl/tx_sticky_flag.sv
module tx_sticky_flag
    import uart_tx_status_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic rd_i,
    input  logic act_i,
    output logic flag_o
);

    flag_state_t st_d, st_q;
    logic        consume;
    logic        keep_arm;

    always_comb begin
        consume    = st_q.armed & act_i;
        keep_arm   = st_q.armed & ~act_i;
        // A live set condition overrides a clearing action
        st_d.flag  = set_i | (st_q.flag & ~consume);
        // Only a status read that saw the flag set arms it
        st_d.armed = st_d.flag & (keep_arm | (rd_i & st_q.flag));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o = st_q.flag;

    assert_hold_unarmed_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.flag && !st_q.armed) |=> st_q.flag)
        else $error("flag cleared without an armed read");

    assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> st_q.flag)
        else $error("set condition lost against a clear");

endmodule

// File: rtl/uart_tx_status.sv
module uart_tx_status
    import uart_tx_status_pkg::*;
#(
    parameter  int FIFO_DEPTH = 8,
    localparam int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] fifo_level,
    input  logic [LVL_W-1:0] tx_watermark,
    input  logic             shifter_busy,
    input  logic             preamble_busy,
    input  logic             break_busy,
    input  logic             stat_rd,
    input  logic             data_wr,
    input  logic             txen_wr,
    input  logic             txen_wdata,
    input  logic             sbk_wr,
    input  logic             sbk_wdata,
    input  logic             empty_ie,
    input  logic             done_ie,
    output logic             tx_empty,
    output logic             tx_done,
    output logic             tx_irq,
    output logic             txd_idle_force
);

    logic [NUM_FLAGS-1:0] set_vec;
    logic [NUM_FLAGS-1:0] act_vec;
    logic [NUM_FLAGS-1:0] flag_vec;
    logic [NUM_FLAGS-1:0] ie_vec;

    tx_set_eval #(.LVL_W(LVL_W)) u_set (
        .level_i      (fifo_level),
        .water_i      (tx_watermark),
        .shift_busy_i (shifter_busy),
        .pre_busy_i   (preamble_busy),
        .brk_busy_i   (break_busy),
        .set_o        (set_vec)
    );

    tx_action_decode u_act (
        .clk          (clk),
        .rst_n        (rst_n),
        .data_wr_i    (data_wr),
        .txen_wr_i    (txen_wr),
        .txen_wdata_i (txen_wdata),
        .sbk_wr_i     (sbk_wr),
        .sbk_wdata_i  (sbk_wdata),
        .act_o        (act_vec)
    );

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
        tx_sticky_flag u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (set_vec[g]),
            .rd_i   (stat_rd),
            .act_i  (act_vec[g]),
            .flag_o (flag_vec[g])
        );
    end

    always_comb begin
        ie_vec             = '0;
        ie_vec[FLAG_EMPTY] = empty_ie;
        ie_vec[FLAG_DONE]  = done_ie;
    end

    assign tx_empty       = flag_vec[FLAG_EMPTY];
    assign tx_done        = flag_vec[FLAG_DONE];
    assign tx_irq         = |(flag_vec & ie_vec);
    assign txd_idle_force = flag_vec[FLAG_DONE];

    assert_empty_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_level <= tx_watermark) |=> tx_empty)
        else $error("empty flag missed its watermark");

    assert_done_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_level == '0 && !shifter_busy && !preamble_busy && !break_busy) |=> tx_done)
        else $error("done flag missed an idle line");

    assert_sbk_zero_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_done && sbk_wr && !sbk_wdata && !data_wr && !txen_wr) |=> tx_done)
        else $error("break write of 0 cleared done");

endmodule

// File: tb/uart_tx_status_test.sv
module uart_tx_status_test;

    typedef struct {
        logic  e;
        logic  d;
        logic  irq;
        logic  idle;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] fifo_level = '0;
    logic [3:0] tx_watermark = 4'd2;
    logic       shifter_busy = 1'b0, preamble_busy = 1'b0, break_busy = 1'b0;
    logic       stat_rd = 1'b0, data_wr = 1'b0, txen_wr = 1'b0, txen_wdata = 1'b0;
    logic       sbk_wr = 1'b0, sbk_wdata = 1'b0, empty_ie = 1'b0, done_ie = 1'b0;
    logic       tx_empty, tx_done, tx_irq, txd_idle_force;

    int   n_checks = 0;
    int   n_fail   = 0;
    bit   finished = 0;
    exp_t exp_q[$];

    always #10 clk = ~clk;

    uart_tx_status #(.FIFO_DEPTH(8)) uut (
        .clk (clk), .rst_n (rst_n),
        .fifo_level (fifo_level), .tx_watermark (tx_watermark),
        .shifter_busy (shifter_busy), .preamble_busy (preamble_busy),
        .break_busy (break_busy), .stat_rd (stat_rd), .data_wr (data_wr),
        .txen_wr (txen_wr), .txen_wdata (txen_wdata), .sbk_wr (sbk_wr),
        .sbk_wdata (sbk_wdata), .empty_ie (empty_ie), .done_ie (done_ie),
        .tx_empty (tx_empty), .tx_done (tx_done), .tx_irq (tx_irq),
        .txd_idle_force (txd_idle_force)
    );

    task automatic check(input string tag, input string name, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", tag, name, act, exp);
        end
    endtask

    // Driver: applies one cycle of strobes and queues the expected outputs
    task automatic step(input logic rd, input logic dw, input logic tw, input logic sw,
                        input logic exp_e, input logic exp_d, input string tag);
        exp_t it;
        stat_rd = rd;
        data_wr = dw;
        txen_wr = tw;
        sbk_wr  = sw;
        it.e    = exp_e;
        it.d    = exp_d;
        it.irq  = (exp_e & empty_ie) | (exp_d & done_ie);   // R12
        it.idle = exp_d;                                     // R6
        it.tag  = tag;
        exp_q.push_back(it);
        @(negedge clk);
    endtask

    // Monitor: compares after each active edge
    always @(posedge clk) begin
        #5;
        if (exp_q.size() > 0) begin
            exp_t it;
            it = exp_q.pop_front();
            check(it.tag, "tx_empty", tx_empty, it.e);
            check(it.tag, "tx_done", tx_done, it.d);
            check({it.tag, "/R12"}, "tx_irq", tx_irq, it.irq);
            check({it.tag, "/R6"}, "txd_idle_force", txd_idle_force, it.idle);
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(20 * 5000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset", "tx_empty", tx_empty, 1'b0);
        check("R1 reset", "tx_done", tx_done, 1'b0);
        check("R12 reset", "tx_irq", tx_irq, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R5: both set conditions true; enable written 1 with nothing armed
        txen_wdata = 1'b1;
        step(0, 0, 1, 0, 1, 1, "R1_R5 set");
        step(1, 0, 0, 0, 1, 1, "R3 arm");
        fifo_level = 4'd3; shifter_busy = 1'b1;
        step(0, 1, 0, 0, 0, 0, "R3_R7 clear");
        fifo_level = 4'd2;
        step(0, 0, 0, 0, 1, 0, "R2 busy ignored");
        step(1, 0, 0, 0, 1, 0, "R3 arm again");
        step(0, 1, 0, 0, 1, 0, "R4 set wins");
        fifo_level = 4'd3;
        step(0, 1, 0, 0, 1, 0, "R11 arm consumed");
        step(1, 0, 0, 0, 1, 0, "R10 arm");
        sbk_wdata = 1'b1;
        step(0, 0, 0, 1, 1, 0, "R10 break write keeps arm");
        step(0, 1, 0, 0, 0, 0, "R10 data write clears");

        empty_ie = 1'b1; done_ie = 1'b1;
        fifo_level = 4'd0; shifter_busy = 1'b0; preamble_busy = 1'b1;
        step(0, 0, 0, 0, 1, 0, "R5 preamble blocks");
        preamble_busy = 1'b0; break_busy = 1'b1;
        step(0, 0, 0, 0, 1, 0, "R5 break blocks");
        break_busy = 1'b0;
        step(0, 0, 0, 0, 1, 1, "R5 idle line");
        step(1, 0, 0, 0, 1, 1, "R7 arm");
        shifter_busy = 1'b1; fifo_level = 4'd3; sbk_wdata = 1'b0;
        step(0, 0, 0, 1, 1, 1, "R9 break 0 ignored");
        txen_wdata = 1'b1;
        step(0, 0, 1, 0, 1, 1, "R10 enable rewrite");
        txen_wdata = 1'b0;
        step(0, 0, 1, 0, 1, 1, "R8 enable clear only");
        txen_wdata = 1'b1;
        step(0, 0, 1, 0, 1, 0, "R8 enable toggle");
        empty_ie = 1'b0;
        step(0, 0, 0, 0, 1, 0, "R12 masked");
        fifo_level = 4'd0; shifter_busy = 1'b0;
        step(0, 0, 0, 0, 1, 1, "R12 done irq");
        step(1, 0, 0, 0, 1, 1, "R9 arm");
        break_busy = 1'b1; sbk_wdata = 1'b1;
        step(0, 0, 0, 1, 1, 0, "R9 break queued");
        break_busy = 1'b0;
        step(0, 0, 0, 0, 1, 1, "R5 resets");
        shifter_busy = 1'b1;
        step(0, 1, 0, 0, 1, 1, "R11 unarmed write");
        step(1, 0, 0, 0, 1, 1, "R7 arm");
        step(1, 1, 0, 0, 1, 0, "R7 read and write");
        step(0, 0, 0, 0, 1, 0, "R7 stays clear");
        @(negedge clk);
        finish_run();
    end

endmodule